// File: doc/BRIEF.md
# Strobe-Written Packet FIFO with Commit

This block is the receive buffer on the peripheral side of a single endpoint. An external master writes bytes with an asynchronous, active-low write strobe. The byte on the data bus is taken when the strobe returns high. A second active-low strobe closes the packet being built, so a short packet can be handed on before it reaches the maximum size. Both strobes cross into the local clock through a two-stage synchronizer. Their rising edges are detected there, and the data bus, the endpoint select lines and chip select are sampled in the same cycle as the edge.

The bytes go into a circular byte store with a post-incremented write pointer. The length of each closed packet goes into a small queue of lengths. The internal side sees the packet at the head of that queue as a byte count and a valid/ready stream with a last-byte marker. Byte space is freed as bytes are read. The external side sees full and empty flags. These flags follow the internal state after a fixed number of pipeline cycles, so they change a set delay after the strobe edge.

A packet that reaches the maximum size is closed automatically. A packet-end strobe with no open bytes either produces a zero-length packet or is ignored, as a parameter selects. A write or packet-end that cannot be stored is dropped and sets a sticky overflow bit.

Top module: `strobe_pkt_fifo`

## Requirements
- R1: After reset `fifo_empty` is 1, `fifo_full` is 0, `overflow` is 0 and `rd_valid` is 0.
- R2: A byte is stored on the deassertion (low-to-high) of `wr_strobe_n`. The value taken is the one on `wr_data` when the strobe returns high, not the one present when it fell. The store takes effect on the third rising clock edge after the strobe rises.
- R3: Bytes are read out in the order they were written. Each write fills the current slot before the write pointer advances.
- R4: A rising edge of `end_strobe_n` closes the open bytes as one packet. `pkt_len` shows its byte count, and `rd_last` is 1 on its final byte and only while `rd_valid` is 1.
- R5: The write that brings the open packet to `MAX_PKT` bytes closes it without a packet-end strobe. `pkt_len` then equals `MAX_PKT`.
- R6: A packet-end with no open bytes makes a zero-length packet when `ZLP_EN` is 1. That packet is one beat with `rd_valid` 1, `pkt_len` 0 and `rd_last` 1, and it consumes no byte. When `ZLP_EN` is 0 the strobe is ignored.
- R7: A strobe is accepted only when `sel_addr` equals `SEL_ID` and `cs_n` is 0 (or `CS_TIED` is 1). Otherwise it changes nothing.
- R8: These events are dropped and set `overflow`, which stays 1 until reset: a write while the byte store holds `DEPTH` bytes or the length queue holds `PKT_SLOTS` packets, and a packet-end while the length queue is full.
- R9: `fifo_full` and `fifo_empty` show the internal state `FLAG_DLY` cycles late. After the edge that stores a byte, `fifo_empty` falls on the (`FLAG_DLY`+3)th rising clock edge after the strobe rises.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `pkt_len` and `rd_data` hold. Every byte read frees one byte of space, so `fifo_full` clears once space is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| wr_strobe_n | input | 1 | Asynchronous write strobe, active low |
| end_strobe_n | input | 1 | Asynchronous packet-end strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| sel_addr | input | SEL_W | Endpoint select lines |
| wr_data | input | DATA_W | Write data bus |
| fifo_full | output | 1 | Delayed full flag to the external side |
| fifo_empty | output | 1 | Delayed empty flag to the external side |
| overflow | output | 1 | Sticky: a strobe was dropped |
| rd_valid | output | 1 | A closed packet is at the head |
| rd_ready | input | 1 | Internal side takes the current beat |
| rd_data | output | DATA_W | Current byte of the head packet |
| rd_last | output | 1 | Current beat is the last of its packet |
| pkt_len | output | LEN_W | Byte count of the head packet |

## Verification
Several properties are checked on every cycle. The overflow bit stays sticky, and the two flags are never set together. The stored byte count never passes the depth, and the open count stays below the maximum packet size. The last marker appears only with a valid beat, and the head length and data hold under back-pressure. Other behaviour can only be shown by the bench's scenarios: which bus value is taken at the strobe's rising edge, byte order across a sweep of packet sizes, automatic closing, zero-length packets, rejection on a wrong select or inactive chip select, and the exact cycle when a flag changes. The drop of bytes into a full store is also shown only by the bench.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam int STB_N   = 2;
    localparam int STB_WR  = 0;
    localparam int STB_END = 1;

    typedef struct packed {
        logic full;
        logic empty;
    } flag_t;

    localparam flag_t FLAG_RST = '{full: 1'b0, empty: 1'b1};
endpackage

// File: rtl/spf_strobe_sync.sv
module spf_strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_n;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync & ~st_q.prev;
endmodule

// File: rtl/spf_byte_store.sv
module spf_byte_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spf_len_queue.sv
module spf_len_queue #(
    parameter int SLOTS = 4,
    parameter int LEN_W = 4,
    localparam int PW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic [LEN_W-1:0] head_len,
    output logic [CW-1:0]    count,
    output logic             full
);
    typedef struct packed {
        logic [SLOTS-1:0][LEN_W-1:0] slot;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.slot[q_q.wp] = push_len;
            q_d.wp           = step(q_q.wp);
        end
        if (pop) q_d.rp = step(q_q.rp);
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_len = q_q.slot[q_q.rp];
    assign count    = q_q.cnt;
    assign full     = (q_q.cnt == CW'(SLOTS));
endmodule

// File: rtl/spf_flag_delay.sv
module spf_flag_delay #(
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spf_pkg::flag_t now_flags,
    output spf_pkg::flag_t late_flags
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign late_flags = now_flags;
        end else begin : g_pipe
            spf_pkg::flag_t pipe_d [STAGES];
            spf_pkg::flag_t pipe_q [STAGES];

            always_comb begin
                pipe_d[0] = now_flags;
                for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe_q[i] <= spf_pkg::FLAG_RST;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign late_flags = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/strobe_pkt_fifo.sv
module strobe_pkt_fifo #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int MAX_PKT   = 8,
    parameter int PKT_SLOTS = 4,
    parameter int SEL_W     = 2,
    parameter int SEL_ID    = 0,
    parameter bit CS_TIED   = 1'b0,
    parameter bit ZLP_EN    = 1'b1,
    parameter int FLAG_DLY  = 2,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe_n,
    input  logic              end_strobe_n,
    input  logic              cs_n,
    input  logic [SEL_W-1:0]  sel_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              overflow,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [LEN_W-1:0]  pkt_len
);
    import spf_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int QC_W  = $clog2(PKT_SLOTS + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] used;
        logic [LEN_W-1:0] open;
        logic [LEN_W-1:0] beat;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [STB_N-1:0] pins_n, rise;
    logic             sel_ok, full_int, wr_hit, do_wr, auto_close;
    logic             end_want, end_commit, end_drop;
    logic             push, pop, take_byte, zero_head;
    logic [LEN_W-1:0] open_nx, push_len, head_len;
    logic [QC_W-1:0]  q_count;
    logic             q_full;
    flag_t            flags_now, flags_late;
    logic [CNT_W-1:0] used_lvl;
    logic [LEN_W-1:0] open_lvl;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign pins_n[STB_WR]  = wr_strobe_n;
    assign pins_n[STB_END] = end_strobe_n;

    spf_strobe_sync #(.N(STB_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (pins_n),
        .rise  (rise)
    );

    spf_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (do_wr),
        .waddr (ctl_q.wptr),
        .wdata (wr_data),
        .raddr (ctl_q.rptr),
        .rdata (rd_data)
    );

    spf_len_queue #(.SLOTS(PKT_SLOTS), .LEN_W(LEN_W)) u_lenq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_len (push_len),
        .pop      (pop),
        .head_len (head_len),
        .count    (q_count),
        .full     (q_full)
    );

    spf_flag_delay #(.STAGES(FLAG_DLY)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_flags  (flags_now),
        .late_flags (flags_late)
    );

    // Read side: head packet presented as a stream.
    assign rd_valid  = (q_count != '0);
    assign zero_head = (head_len == '0);
    assign rd_last   = rd_valid && (zero_head || (ctl_q.beat + LEN_W'(1) == head_len));
    assign pkt_len   = head_len;

    always_comb begin
        ctl_d = ctl_q;

        // Write side qualification
        sel_ok   = (sel_addr == SEL_W'(SEL_ID)) && (CS_TIED || !cs_n);
        full_int = (ctl_q.used == CNT_W'(DEPTH)) || q_full;
        wr_hit   = rise[STB_WR] && sel_ok;
        do_wr    = wr_hit && !full_int;

        open_nx    = ctl_q.open + LEN_W'(do_wr);
        auto_close = do_wr && (open_nx == LEN_W'(MAX_PKT));

        // Packet-end: skipped when the same cycle already closed a full packet
        end_want   = rise[STB_END] && sel_ok && !auto_close &&
                     ((open_nx != '0) || ZLP_EN);
        end_commit = end_want && !q_full;
        end_drop   = end_want && q_full;

        push     = auto_close || end_commit;
        push_len = auto_close ? LEN_W'(MAX_PKT) : open_nx;

        // Read consumption
        take_byte = rd_valid && rd_ready && !zero_head;
        pop       = rd_valid && rd_ready && rd_last;

        ctl_d.open = push ? '0 : open_nx;
        if (do_wr) ctl_d.wptr = step(ctl_q.wptr);
        if (take_byte) begin
            ctl_d.rptr = step(ctl_q.rptr);
            ctl_d.beat = pop ? '0 : ctl_q.beat + LEN_W'(1);
        end
        ctl_d.used = ctl_q.used + CNT_W'(do_wr) - CNT_W'(take_byte);
        ctl_d.ovf  = ctl_q.ovf || (wr_hit && full_int) || end_drop;

        flags_now.full  = full_int;
        flags_now.empty = (ctl_q.used == '0) && (q_count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fifo_full  = flags_late.full;
    assign fifo_empty = flags_late.empty;
    assign overflow   = ctl_q.ovf;
    assign used_lvl   = ctl_q.used;
    assign open_lvl   = ctl_q.open;
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int MAX_PKT = 8,
    parameter int CNT_W   = 5,
    parameter int LEN_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              overflow,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_last,
    input logic [DATA_W-1:0] rd_data,
    input logic [LEN_W-1:0]  pkt_len,
    input logic [CNT_W-1:0]  used_lvl,
    input logic [LEN_W-1:0]  open_lvl
);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r4_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (pkt_len <= LEN_W'(MAX_PKT)));

    a_r10_stall_holds_len: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(pkt_len)));

    a_r10_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && pkt_len != '0) |=> $stable(rd_data));

    a_r5_open_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        open_lvl < LEN_W'(MAX_PKT));

    a_r8_used_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        used_lvl <= CNT_W'(DEPTH));
endmodule

bind strobe_pkt_fifo spf_checker #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .MAX_PKT (MAX_PKT),
    .CNT_W   (CNT_W),
    .LEN_W   (LEN_W)
) u_spf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .overflow   (overflow),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_last    (rd_last),
    .rd_data    (rd_data),
    .pkt_len    (pkt_len),
    .used_lvl   (used_lvl),
    .open_lvl   (open_lvl)
);

// File: tb/strobe_pkt_fifo_bench.sv
module strobe_pkt_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W    = 8;
    localparam int DEPTH     = 16;
    localparam int MAX_PKT   = 8;
    localparam int PKT_SLOTS = 4;
    localparam int SEL_W     = 2;
    localparam int SEL_ID    = 1;
    localparam int FLAG_DLY  = 2;
    localparam int LEN_W     = $clog2(MAX_PKT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_n = 1'b1, end_n = 1'b1, cs_n = 1'b0;
    logic [SEL_W-1:0]  sel = SEL_W'(SEL_ID);
    logic [DATA_W-1:0] data = '0;
    logic              full, empty, ovf, rd_valid, rd_last;
    logic              rd_ready = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [LEN_W-1:0]  pkt_len;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_pkt_fifo #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT), .PKT_SLOTS(PKT_SLOTS),
        .SEL_W(SEL_W), .SEL_ID(SEL_ID), .CS_TIED(1'b0), .ZLP_EN(1'b1),
        .FLAG_DLY(FLAG_DLY)
    ) u_strobe_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .wr_strobe_n(wr_n), .end_strobe_n(end_n),
        .cs_n(cs_n), .sel_addr(sel), .wr_data(data), .fifo_full(full),
        .fifo_empty(empty), .overflow(ovf), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .pkt_len(pkt_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One write strobe; bus shows junk when the strobe falls, the real byte before it rises.
    task automatic put(input logic [DATA_W-1:0] b, input logic [SEL_W-1:0] a,
                       input logic c, input bit keep);
        @(negedge clk); sel = a; cs_n = c; data = ~b; wr_n = 1'b0;
        @(negedge clk); data = b;
        @(negedge clk); wr_n = 1'b1;
        repeat (4) @(negedge clk);
        sel = SEL_W'(SEL_ID); cs_n = 1'b0;
        if (keep) model.push_back(b);
    endtask

    task automatic close_pkt();
        @(negedge clk); end_n = 1'b0;
        repeat (2) @(negedge clk);
        end_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        repeat (FLAG_DLY + 2) @(negedge clk);
    endtask

    task automatic read_pkt(input int len, input string req);
        logic [DATA_W-1:0] exp_b, held;
        for (int k = 0; k < 20 && !rd_valid; k++) @(negedge clk);
        chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
        chk(int'(pkt_len) == len, req, int'(pkt_len), len);
        if (len == 0) begin
            chk(rd_last == 1'b1, "R6 zero-length last", int'(rd_last), 1);
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end else begin
            held = rd_data;
            repeat (2) @(negedge clk);
            chk(rd_data == held && int'(pkt_len) == len, "R10 stall hold",
                int'(rd_data), int'(held));
            for (int i = 0; i < len; i++) begin
                exp_b = model.pop_front();
                chk(rd_data == exp_b, "R3 byte order", int'(rd_data), int'(exp_b));
                chk(rd_last == (i == len - 1), "R4 last marker", int'(rd_last),
                    int'(i == len - 1));
                rd_ready = 1'b1;
                @(negedge clk);
            end
            rd_ready = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(full == 1'b0, "R1 full", int'(full), 0);
        chk(ovf == 1'b0, "R1 overflow", int'(ovf), 0);
        chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);

        // R2 capture on strobe rise, R9 exact flag delay
        @(negedge clk); data = 8'h5A; wr_n = 1'b0;
        @(negedge clk); data = 8'hA5;
        @(negedge clk); wr_n = 1'b1;
        repeat (2 + FLAG_DLY) @(negedge clk);
        chk(empty == 1'b1, "R9 empty before delay", int'(empty), 1);
        @(negedge clk);
        chk(empty == 1'b0, "R9 empty after delay", int'(empty), 0);
        model.push_back(8'hA5);
        close_pkt();
        read_pkt(1, "R2 single byte packet");

        // R3/R4 sweep over short packet sizes
        for (int n = 2; n < MAX_PKT; n++) begin
            for (int i = 0; i < n; i++) put(DATA_W'(n * 16 + i), SEL_W'(SEL_ID), 1'b0, 1'b1);
            close_pkt();
            read_pkt(n, "R4 short packet length");
        end

        // R7 select and chip-select qualification
        put(8'h11, SEL_W'(SEL_ID), 1'b0, 1'b1);
        put(8'h22, SEL_W'(SEL_ID + 1), 1'b0, 1'b0);
        put(8'h33, SEL_W'(SEL_ID), 1'b1, 1'b0);
        put(8'h44, SEL_W'(SEL_ID), 1'b0, 1'b1);
        put(8'h55, SEL_W'(SEL_ID), 1'b0, 1'b1);
        @(negedge clk); sel = SEL_W'(SEL_ID + 1); end_n = 1'b0;
        repeat (2) @(negedge clk); end_n = 1'b1;
        repeat (4) @(negedge clk); sel = SEL_W'(SEL_ID);
        chk(rd_valid == 1'b0, "R7 foreign packet-end ignored", int'(rd_valid), 0);
        close_pkt();
        read_pkt(3, "R7 rejected strobes excluded");

        // R5 automatic close at the maximum size
        for (int i = 0; i < MAX_PKT; i++) put(DATA_W'(8'hC0 + i), SEL_W'(SEL_ID), 1'b0, 1'b1);
        read_pkt(MAX_PKT, "R5 auto close");

        // R6 zero-length packets, R8 queue full drop
        for (int i = 0; i < PKT_SLOTS; i++) close_pkt();
        settle();
        chk(full == 1'b1, "R8 queue full flag", int'(full), 1);
        chk(ovf == 1'b0, "R8 no overflow yet", int'(ovf), 0);
        close_pkt();
        chk(ovf == 1'b1, "R8 overflow on dropped end", int'(ovf), 1);
        for (int i = 0; i < PKT_SLOTS; i++) read_pkt(0, "R6 zero-length packet");
        settle();
        chk(rd_valid == 1'b0, "R8 dropped end made no packet", int'(rd_valid), 0);
        chk(full == 1'b0 && empty == 1'b1, "R10 flags after drain",
            int'({full, empty}), 1);

        // R8 byte store full: extra byte dropped
        for (int i = 0; i < DEPTH; i++) put(DATA_W'(8'h80 + i), SEL_W'(SEL_ID), 1'b0, 1'b1);
        settle();
        chk(full == 1'b1, "R8 store full flag", int'(full), 1);
        put(8'hEE, SEL_W'(SEL_ID), 1'b0, 1'b0);
        read_pkt(MAX_PKT, "R8 first full packet");
        settle();
        chk(full == 1'b0, "R10 space freed", int'(full), 0);
        read_pkt(MAX_PKT, "R8 second full packet");
        settle();
        chk(rd_valid == 1'b0, "R8 dropped byte absent", int'(rd_valid), 0);
        chk(ovf == 1'b1, "R8 overflow sticky", int'(ovf), 1);
        put(8'h77, SEL_W'(SEL_ID), 1'b0, 1'b1);
        close_pkt();
        read_pkt(1, "R3 after wrap");
        settle();
        chk(empty == 1'b1, "R9 empty at end", int'(empty), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule